// File: doc/BRIEF.md
# Embedded Operation Status Flag Generator

This block sits on the read path of a non-volatile memory and decides what a host read returns. The memory runs program and erase operations on its own after the host writes a command. While such an operation is pending or running, a read does not return array contents. It returns a status byte instead. The host polls this byte to follow the operation's progress and to see when it ends.

The status byte carries four live flags. Bit 7 is a polling bit. For a program operation it reads as the inverse of bit 7 of the byte being written. For an erase operation it reads 0. Bit 6 flips once on every read access. Bit 5 reports that the operation ran past its time limit. Bit 3 reports whether the erase acceptance window has closed, so that the real erase has begun. When no operation is pending and no time-limit fault is held, reads pass the array data through unchanged.

The read path is a plain strobe with combinational data. There is no valid/ready handshake, because a read cannot be held back. The operation engine drives the busy, window and timeout inputs. The command decoder drives the fault-clear pulse.

Top module: `op_status_gen`

## Requirements
- R1: When busy, erase-window-open and the held fault are all 0, rd_data equals arr_data in the same cycle.
- R2: While status is returned for a program operation (op_erase=0), rd_data[7] equals the inverse of wr_byte[7].
- R3: While status is returned for an erase operation (op_erase=1), rd_data[7] is 0. Once busy falls with no fault held, the read returns the array, so an erased byte (FFh) shows bit 7 as 1.
- R4: Each read access flips rd_data[6] while status is returned. An access is counted when rd_stb is 1 at a clock edge after being 0 at the previous edge. The flip is visible from that edge onward. A strobe held high for many cycles counts once. This holds during the erase acceptance window as well as while busy.
- R5: rd_data[3] is 0 while the erase window is open. It is 1 during an erase with busy=1 and the window closed. It is 0 for a program operation.
- R6: A timeout pulse seen while busy or while the window is open sets a held fault that drives rd_data[5] to 1 from the next edge. The fault keeps status mode on after busy falls. Only a clr_fail pulse removes it, and clr_fail wins over a timeout pulse in the same cycle.
- R7: While status is returned, rd_data bits 4, 2, 1 and 0 read 0.
- R8: After reset, the held fault is 0 and the toggle state is 0, so the first read access during an operation shows rd_data[6]=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_erase | input | 1 | Operation kind: 1 erase, 0 program |
| busy | input | 1 | Internal operation in progress |
| erase_win | input | 1 | Sector-erase acceptance window open |
| timeout | input | 1 | Operation exceeded its time limit (pulse) |
| clr_fail | input | 1 | Reset command written; clears the held fault |
| wr_byte | input | 8 | Byte being programmed |
| rd_stb | input | 1 | Host read strobe |
| arr_data | input | 8 | Array data for the current address |
| rd_data | output | 8 | Byte returned to the host |

## Verification
Program status is tried with written bytes whose bit 7 is both 1 and 0. This separates a true inversion from a constant. Erase status is tried with the window open and then closed, which tells the two bit-3 states apart, and an FFh array read after completion shows the return to array data. Toggle behaviour is tried with back-to-back short reads and with one long read, which separates edge counting from level counting. A timeout followed by busy falling, then a timeout coinciding with a clear, shows that the fault is held and that the clear has priority.

// File: rtl/op_status_pkg.sv
package op_status_pkg;
  localparam int BYTE_W   = 8;
  localparam int POLL_BIT = 7;
  localparam int TOG_BIT  = 6;
  localparam int FAIL_BIT = 5;
  localparam int WIN_BIT  = 3;
endpackage

// File: rtl/op_status_toggle.sv
module op_status_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic rd_stb,
  output logic tog
);
  logic stb_q;
  logic access;

  assign access = rd_stb & ~stb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_q <= 1'b0;
      tog   <= 1'b0;
    end else begin
      stb_q <= rd_stb;
      if (access && active) tog <= ~tog;
    end
  end
endmodule

// File: rtl/op_status_fault.sv
module op_status_fault (
  input  logic clk,
  input  logic rst_n,
  input  logic running,
  input  logic timeout,
  input  logic clr_fail,
  output logic fail_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   fail_q <= 1'b0;
    else if (clr_fail)            fail_q <= 1'b0;
    else if (timeout && running)  fail_q <= 1'b1;
  end
endmodule

// File: rtl/op_status_gen.sv
module op_status_gen
  import op_status_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_erase,
  input  logic              busy,
  input  logic              erase_win,
  input  logic              timeout,
  input  logic              clr_fail,
  input  logic [BYTE_W-1:0] wr_byte,
  input  logic              rd_stb,
  input  logic [BYTE_W-1:0] arr_data,
  output logic [BYTE_W-1:0] rd_data
);
  logic running;
  logic fail_q;
  logic active;
  logic tog;
  logic [BYTE_W-1:0] status;

  assign running = busy | erase_win;
  assign active  = running | fail_q;

  op_status_fault u_fault (
    .clk(clk), .rst_n(rst_n), .running(running),
    .timeout(timeout), .clr_fail(clr_fail), .fail_q(fail_q)
  );

  op_status_toggle u_tog (
    .clk(clk), .rst_n(rst_n), .active(active),
    .rd_stb(rd_stb), .tog(tog)
  );

  always_comb begin
    status           = '0;
    status[POLL_BIT] = op_erase ? 1'b0 : ~wr_byte[POLL_BIT];
    status[TOG_BIT]  = tog;
    status[FAIL_BIT] = fail_q;
    status[WIN_BIT]  = op_erase & busy & ~erase_win;
  end

  assign rd_data = active ? status : arr_data;
endmodule

// File: rtl/op_status_chk.sv
module op_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       op_erase,
  input logic       busy,
  input logic       erase_win,
  input logic       timeout,
  input logic       clr_fail,
  input logic [7:0] wr_byte,
  input logic       rd_stb,
  input logic [7:0] arr_data,
  input logic [7:0] rd_data,
  input logic       fail_q
);
  logic stb_seen;
  logic act;
  logic rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stb_seen <= 1'b0;
    else        stb_seen <= rd_stb;
  end

  assign act  = busy | erase_win | fail_q;
  assign rise = rd_stb & ~stb_seen;

  assert_passthru_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !act |-> rd_data == arr_data);

  assert_prog_poll_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (act && !op_erase) |-> rd_data[7] == ~wr_byte[7]);

  assert_erase_poll_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (act && op_erase) |-> rd_data[7] == 1'b0);

  assert_toggle_flip_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (act && rise) |=> (!act || rd_data[6] != $past(rd_data[6])));

  assert_toggle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (act && !rise) |=> (!act || $stable(rd_data[6])));

  assert_window_open_R5: assert property (@(posedge clk) disable iff (!rst_n)
    erase_win |-> rd_data[3] == 1'b0);

  assert_fault_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout && (busy || erase_win) && !clr_fail) |=> rd_data[5]);

  assert_fault_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_fail |=> !fail_q);

  assert_zero_bits_R7: assert property (@(posedge clk) disable iff (!rst_n)
    act |-> (rd_data[4] == 1'b0 && rd_data[2:0] == 3'b000));
endmodule

bind op_status_gen op_status_chk u_chk (
  .clk(clk), .rst_n(rst_n), .op_erase(op_erase), .busy(busy),
  .erase_win(erase_win), .timeout(timeout), .clr_fail(clr_fail),
  .wr_byte(wr_byte), .rd_stb(rd_stb), .arr_data(arr_data),
  .rd_data(rd_data), .fail_q(fail_q)
);

// File: tb/sim_op_status_gen.sv
`timescale 1ns/1ps
module sim_op_status_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_erase = 1'b0, busy = 1'b0, erase_win = 1'b0;
  logic       timeout = 1'b0, clr_fail = 1'b0, rd_stb = 1'b0;
  logic [7:0] wr_byte = 8'h00, arr_data = 8'h00;
  logic [7:0] rd_data;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  op_status_gen u0 (
    .clk(clk), .rst_n(rst_n), .op_erase(op_erase), .busy(busy),
    .erase_win(erase_win), .timeout(timeout), .clr_fail(clr_fail),
    .wr_byte(wr_byte), .rd_stb(rd_stb), .arr_data(arr_data), .rd_data(rd_data)
  );

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one short read access; returns bit 6 seen after the counting edge
  task automatic read_once(output logic b6);
    rd_stb = 1'b1; cyc(1);
    b6 = rd_data[6];
    rd_stb = 1'b0; cyc(1);
  endtask

  task automatic t_reset();
    chk("R1 reset passthru", rd_data, 8'h00);
    arr_data = 8'hA5; #1;
    chk("R1 idle passthru", rd_data, 8'hA5);
  endtask

  task automatic t_first_read();
    logic b;
    op_erase = 1'b0; wr_byte = 8'h80; busy = 1'b1; cyc(1);
    chk("R8 toggle starts at 0", {7'b0, rd_data[6]}, 8'h00);
    read_once(b);
    chk("R8 first read bit6", {7'b0, b}, 8'h01);
  endtask

  task automatic t_program();
    logic b1, b2, b3;
    wr_byte = 8'h80; #1;
    chk("R2 poll for bit7=1", {7'b0, rd_data[7]}, 8'h00);
    wr_byte = 8'h7F; #1;
    chk("R2 poll for bit7=0", {7'b0, rd_data[7]}, 8'h01);
    chk("R7 zero bits prog", rd_data & 8'h17, 8'h00);
    chk("R5 bit3 prog", {7'b0, rd_data[3]}, 8'h00);
    read_once(b1); read_once(b2); read_once(b3);
    chk("R4 successive reads differ", {7'b0, b1 ^ b2}, 8'h01);
    chk("R4 third read differs", {7'b0, b2 ^ b3}, 8'h01);
    busy = 1'b0; arr_data = 8'h7F; #1;
    chk("R1 back to array after program", rd_data, 8'h7F);
  endtask

  task automatic t_long_read();
    logic b0, b1, b2;
    busy = 1'b1; cyc(1);
    b0 = rd_data[6];
    rd_stb = 1'b1; cyc(1);
    b1 = rd_data[6];
    cyc(5);
    b2 = rd_data[6];
    rd_stb = 1'b0; cyc(1);
    chk("R4 long read flips once", {7'b0, b0 ^ b1}, 8'h01);
    chk("R4 long read no extra flips", {7'b0, b2}, {7'b0, b1});
    busy = 1'b0; cyc(1);
  endtask

  task automatic t_erase();
    logic b1, b2;
    op_erase = 1'b1; erase_win = 1'b1; arr_data = 8'h00; cyc(1);
    chk("R3 erase poll in window", {7'b0, rd_data[7]}, 8'h00);
    chk("R5 window open bit3", {7'b0, rd_data[3]}, 8'h00);
    read_once(b1); read_once(b2);
    chk("R4 toggles in window", {7'b0, b1 ^ b2}, 8'h01);
    erase_win = 1'b0; busy = 1'b1; cyc(1);
    chk("R5 erase begun bit3", {7'b0, rd_data[3]}, 8'h01);
    chk("R3 erase poll busy", {7'b0, rd_data[7]}, 8'h00);
    chk("R7 zero bits erase", rd_data & 8'h17, 8'h00);
    busy = 1'b0; arr_data = 8'hFF; #1;
    chk("R3 done reads 1 on bit7", rd_data, 8'hFF);
  endtask

  task automatic t_fault();
    op_erase = 1'b0; wr_byte = 8'h00; busy = 1'b1; arr_data = 8'h3C;
    timeout = 1'b1; cyc(1); timeout = 1'b0;
    chk("R6 fault bit5 set", {7'b0, rd_data[5]}, 8'h01);
    busy = 1'b0; cyc(2);
    chk("R6 fault holds status", rd_data & 8'hA0, 8'hA0);
    clr_fail = 1'b1; cyc(1); clr_fail = 1'b0;
    chk("R6 clear returns array", rd_data, 8'h3C);
    busy = 1'b1; timeout = 1'b1; clr_fail = 1'b1; cyc(1);
    timeout = 1'b0; clr_fail = 1'b0;
    chk("R6 clear wins", {7'b0, rd_data[5]}, 8'h00);
    busy = 1'b0; #1;
    chk("R6 no fault after clear win", rd_data, 8'h3C);
    timeout = 1'b1; cyc(1); timeout = 1'b0;
    chk("R6 timeout ignored when idle", rd_data, 8'h3C);
  endtask

  initial begin
    cyc(2); rst_n = 1'b1; cyc(1);
    t_reset();
    t_first_read();
    t_program();
    t_long_read();
    t_erase();
    t_fault();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog got timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule